// File: doc/BRIEF.md
# Latched Overtemperature Trip Detector

This block watches one of two remote temperature channels against that channel's thermal limit. It drives an active-low overtemperature pin, a request that forces the fans to full speed, and a status bit for the interrupt logic. Temperatures and limits are signed fixed-point words with two fractional bits, so one LSB is 0.25 °C. A trip happens when a valid sample of the selected channel is at least one LSB above its limit.

A configuration bit chooses between two modes. In follow mode the trip state is recomputed on every valid sample. In latch mode a trip holds until a sample falls strictly below the limit, and the status bit clears at that moment. The pin function must be enabled before anything drives. The full-speed request can be turned off on its own. The package supplies the usual power-on limits: 100 °C for channel A and 136 °C for channel B.

Top module: `thermal_trip`

## Requirements
- R1: After reset, overTempN is 1, fanFullReq is 0 and tripStatus is 0.
- R2: In follow mode (latchEn=0), a valid sample of the selected channel with temp ≥ limit + 1 LSB sets the trip, which is visible at the outputs on the cycle after the sample. A sample equal to the limit does not set it.
- R3: In follow mode, a valid selected sample with temp ≤ limit clears the trip on the next cycle.
- R4: In latch mode (latchEn=1), a set trip stays set through samples with temp ≥ limit (including equal). It clears only on a sample with temp < limit.
- R5: tripStatus is 1 exactly while the trip is active (overTempN=0), and falls in the same cycle the latch releases.
- R6: fanFullReq equals (trip active AND fanForceDis=0).
- R7: While pinEn=0, the trip is cleared on the next edge and stays cleared regardless of samples.
- R8: chSel=0 selects channel A (tempA, validA, limitA) and chSel=1 selects channel B. Valid samples of the unselected channel have no effect on the outputs.
- R9: With pinEn=1 and no valid selected sample, all outputs hold their value.
- R10: Comparisons are two's-complement signed, so negative temperatures and limits order correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempA | input | TEMP_W | Channel A temperature, signed, 0.25 °C/LSB |
| validA | input | 1 | Channel A sample strobe |
| tempB | input | TEMP_W | Channel B temperature, signed, 0.25 °C/LSB |
| validB | input | 1 | Channel B sample strobe |
| limitA | input | TEMP_W | Channel A thermal limit, signed |
| limitB | input | TEMP_W | Channel B thermal limit, signed |
| chSel | input | 1 | Monitored channel: 0 = A, 1 = B |
| latchEn | input | 1 | 1 = latch mode, 0 = follow mode |
| fanForceDis | input | 1 | 1 = do not request full fan speed |
| pinEn | input | 1 | Enables the overtemperature function |
| overTempN | output | 1 | Overtemperature pin, active low |
| fanFullReq | output | 1 | Full fan speed request |
| tripStatus | output | 1 | Trip status bit for the interrupt logic |

## Verification
The assertions check on every cycle that the three outputs agree with each other (R5, R6), that the trip holds without a selected sample (R9) and that a disabled pin leaves it cleared (R7). They also check the one-cycle response to hot, at-limit and cool samples in both modes. Only the bench's scenarios show the sequence behaviour end to end: a latched trip riding through at-limit samples, a channel switch mid-event ignoring the other channel's strobes, and signed negative limits. These are run with directed cases and a long seeded random run near the limits.

// File: rtl/thermal_trip_pkg.sv
`timescale 1ns/1ps
package thermal_trip_pkg;
  localparam int NUM_CH = 2;
  localparam int DEF_TEMP_W = 12;
  // Power-on limits, 0.25 degC per LSB
  localparam int DEF_LIMIT_A = 100 * 4;
  localparam int DEF_LIMIT_B = 136 * 4;

  // Strobes from datapath to control
  typedef struct packed {
    logic sample;  // valid sample on the selected channel
    logic above;   // sample >= limit + 1 LSB
    logic below;   // sample < limit
  } tripStrobe_t;
endpackage

// File: rtl/thermal_trip_datapath.sv
`timescale 1ns/1ps
module thermal_trip_datapath
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W = DEF_TEMP_W
) (
  input  logic signed [TEMP_W-1:0] tempA,
  input  logic                     validA,
  input  logic signed [TEMP_W-1:0] tempB,
  input  logic                     validB,
  input  logic signed [TEMP_W-1:0] limitA,
  input  logic                     validDummy,
  input  logic signed [TEMP_W-1:0] limitB,
  input  logic                     chSel,
  output tripStrobe_t              strobe
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic signed [TEMP_W-1:0] chTemp  [NUM_CH];
  logic signed [TEMP_W-1:0] chLimit [NUM_CH];
  logic [NUM_CH-1:0] chValid;
  logic [NUM_CH-1:0] chAbove;
  logic [NUM_CH-1:0] chBelow;
  logic [SEL_W-1:0]  selIdx;

  assign chTemp[0]  = tempA;
  assign chTemp[1]  = tempB;
  assign chLimit[0] = limitA;
  assign chLimit[1] = limitB;
  assign chValid    = {validB, validA};
  assign selIdx     = SEL_W'(chSel);

  // One signed comparator pair per channel; strict greater-than is
  // the same as temp >= limit + 1 LSB without overflow at full scale.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign chAbove[c] = chTemp[c] > chLimit[c];
    assign chBelow[c] = chTemp[c] < chLimit[c];
  end

  logic unusedOk;
  assign unusedOk = validDummy;

  always_comb begin
    strobe.sample = chValid[selIdx];
    strobe.above  = chAbove[selIdx];
    strobe.below  = chBelow[selIdx];
  end
endmodule

// File: rtl/thermal_trip_control.sv
`timescale 1ns/1ps
module thermal_trip_control
  import thermal_trip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tripStrobe_t strobe,
  input  logic        latchEn,
  input  logic        fanForceDis,
  input  logic        pinEn,
  output logic        overTempN,
  output logic        fanFullReq,
  output logic        tripStatus
);
  logic tripQ;
  logic tripD;

  always_comb begin
    tripD = tripQ;
    if (!pinEn) begin
      tripD = 1'b0;
    end else if (strobe.sample) begin
      if (strobe.above)      tripD = 1'b1;
      else if (!latchEn)     tripD = 1'b0;
      else if (strobe.below) tripD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tripQ <= 1'b0;
    else       tripQ <= tripD;
  end

  assign overTempN  = ~tripQ;
  assign fanFullReq = tripQ & ~fanForceDis;
  assign tripStatus = tripQ;
endmodule

// File: rtl/thermal_trip.sv
`timescale 1ns/1ps
module thermal_trip
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W = DEF_TEMP_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [TEMP_W-1:0] tempA,
  input  logic                     validA,
  input  logic signed [TEMP_W-1:0] tempB,
  input  logic                     validB,
  input  logic signed [TEMP_W-1:0] limitA,
  input  logic signed [TEMP_W-1:0] limitB,
  input  logic                     chSel,
  input  logic                     latchEn,
  input  logic                     fanForceDis,
  input  logic                     pinEn,
  output logic                     overTempN,
  output logic                     fanFullReq,
  output logic                     tripStatus
);
  tripStrobe_t strobe;

  thermal_trip_datapath #(.TEMP_W(TEMP_W)) u_dp (
    .tempA(tempA), .validA(validA), .tempB(tempB), .validB(validB),
    .limitA(limitA), .validDummy(1'b0), .limitB(limitB),
    .chSel(chSel), .strobe(strobe)
  );

  thermal_trip_control u_ctl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .latchEn(latchEn),
    .fanForceDis(fanForceDis), .pinEn(pinEn), .overTempN(overTempN),
    .fanFullReq(fanFullReq), .tripStatus(tripStatus)
  );
endmodule

// File: rtl/thermal_trip_chk.sv
`timescale 1ns/1ps
module thermal_trip_chk #(
  parameter int TEMP_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic signed [TEMP_W-1:0] tempA,
  input logic                     validA,
  input logic signed [TEMP_W-1:0] tempB,
  input logic                     validB,
  input logic signed [TEMP_W-1:0] limitA,
  input logic signed [TEMP_W-1:0] limitB,
  input logic                     chSel,
  input logic                     latchEn,
  input logic                     fanForceDis,
  input logic                     pinEn,
  input logic                     overTempN,
  input logic                     fanFullReq,
  input logic                     tripStatus
);
  logic signed [TEMP_W-1:0] selTemp;
  logic signed [TEMP_W-1:0] selLimit;
  logic selValid;
  assign selTemp  = chSel ? tempB  : tempA;
  assign selLimit = chSel ? limitB : limitA;
  assign selValid = chSel ? validB : validA;

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    tripStatus == !overTempN); // R5
  AST_FAN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    fanFullReq == (!overTempN && !fanForceDis)); // R6
  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pinEn |=> overTempN); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    pinEn && !selValid |=> $stable(overTempN)); // R9
  AST_HOT_TRIPS: assert property (@(posedge clk) disable iff (!rstN)
    pinEn && selValid && (selTemp > selLimit) |=> !overTempN); // R2
  AST_FOLLOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    pinEn && selValid && !latchEn && (selTemp <= selLimit) |=> overTempN); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pinEn && selValid && latchEn && !overTempN && (selTemp >= selLimit)
    |=> !overTempN); // R4
  AST_COOL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    pinEn && selValid && (selTemp < selLimit) |=> overTempN); // R4
endmodule

bind thermal_trip thermal_trip_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .tempA(tempA), .validA(validA), .tempB(tempB),
  .validB(validB), .limitA(limitA), .limitB(limitB), .chSel(chSel),
  .latchEn(latchEn), .fanForceDis(fanForceDis), .pinEn(pinEn),
  .overTempN(overTempN), .fanFullReq(fanFullReq), .tripStatus(tripStatus)
);

// File: tb/thermal_trip_bench.sv
`timescale 1ns/1ps
module thermal_trip_bench;
  import thermal_trip_pkg::*;
  localparam int W = DEF_TEMP_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [W-1:0] tempA = '0, tempB = '0;
  logic signed [W-1:0] limitA = W'(DEF_LIMIT_A), limitB = W'(DEF_LIMIT_B);
  logic validA = 0, validB = 0, chSel = 0, latchEn = 0, fanForceDis = 0, pinEn = 0;
  logic overTempN, fanFullReq, tripStatus;

  int checks = 0, fails = 0;
  bit expTrip = 0;
  bit done = 0;

  always #5 clk = ~clk;

  thermal_trip u_thermal_trip (
    .clk(clk), .rstN(rstN), .tempA(tempA), .validA(validA), .tempB(tempB),
    .validB(validB), .limitA(limitA), .limitB(limitB), .chSel(chSel),
    .latchEn(latchEn), .fanForceDis(fanForceDis), .pinEn(pinEn),
    .overTempN(overTempN), .fanFullReq(fanFullReq), .tripStatus(tripStatus)
  );

  // Expected trip state from the requirements (R2, R3, R4, R7, R8, R10)
  function automatic bit modelNext(bit cur);
    logic signed [W-1:0] t, l;
    bit v;
    t = chSel ? tempB : tempA;
    l = chSel ? limitB : limitA;
    v = chSel ? validB : validA;
    if (!pinEn) return 0;
    if (!v) return cur;
    if (t > l) return 1;
    if (!latchEn) return 0;
    if (t < l) return 0;
    return cur;
  endfunction

  task automatic check(string tag);
    bit eN, eF, eS;
    eN = !expTrip; eF = expTrip && !fanForceDis; eS = expTrip;
    checks++;
    if (overTempN !== eN || fanFullReq !== eF || tripStatus !== eS) begin
      fails++;
      $display("FAIL %s: got nOT=%b fan=%b st=%b expected nOT=%b fan=%b st=%b",
               tag, overTempN, fanFullReq, tripStatus, eN, eF, eS);
    end
  endtask

  // Called at a negedge with inputs set; advances one cycle and checks
  task automatic step(string tag);
    @(posedge clk);
    expTrip = modelNext(expTrip);
    @(negedge clk);
    check(tag);
    validA = 0; validB = 0;
  endtask

  task automatic sampleA(int t, string tag);
    tempA = W'(t); validA = 1; step(tag);
  endtask

  task automatic sampleB(int t, string tag);
    tempB = W'(t); validB = 1; step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 reset");
    rstN = 1;
    @(negedge clk);
    check("R1 after release");
    pinEn = 1;

    // Follow mode on channel A, limit 400
    sampleA(DEF_LIMIT_A, "R2 equal no trip");
    sampleA(DEF_LIMIT_A + 1, "R2 one LSB above trips");
    step("R9 hold idle");
    sampleA(DEF_LIMIT_A, "R3 equal clears in follow");
    sampleA(DEF_LIMIT_A + 8, "R2 retrip");
    fanForceDis = 1; step("R6 fan disabled");
    fanForceDis = 0; step("R6 fan re-enabled");
    sampleA(DEF_LIMIT_A - 4, "R3 below clears");

    // Latch mode
    latchEn = 1;
    sampleA(DEF_LIMIT_A + 1, "R4 latch set");
    sampleA(DEF_LIMIT_A, "R4 equal holds");
    step("R9 hold latched");
    sampleA(DEF_LIMIT_A - 1, "R5 release clears status");
    sampleA(DEF_LIMIT_A, "R4 equal no set");

    // Channel select: B with limit 544
    chSel = 1;
    sampleA(2000, "R8 unselected A ignored");
    sampleB(DEF_LIMIT_B + 1, "R8 channel B trips");
    sampleA(-100, "R8 unselected A cold ignored");
    pinEn = 0; step("R7 pin disabled clears");
    sampleB(2000, "R7 hot ignored when disabled");
    pinEn = 1;

    // Signed limits
    chSel = 0; latchEn = 0;
    limitA = -W'(40);
    sampleA(-39, "R10 negative above trips");
    sampleA(-41, "R10 negative below clears");
    sampleA(5, "R10 positive vs negative limit");
    limitA = W'(DEF_LIMIT_A);

    // Random near-limit run
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      chSel = (r == 0) ? ~chSel : chSel;
      latchEn = (r == 1) ? ~latchEn : latchEn;
      fanForceDis = (r == 2) ? ~fanForceDis : fanForceDis;
      pinEn = (r == 3) ? 1'b0 : 1'b1;
      tempA = W'(DEF_LIMIT_A + int'($urandom % 7) - 3);
      tempB = W'(DEF_LIMIT_B + int'($urandom % 7) - 3);
      validA = $urandom % 2;
      validB = $urandom % 2;
      step("R2/R3/R4/R6/R7/R8/R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule